// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block keeps the processor mode state of a 32-bit core with a windowed register file. That state is the trap-enable bit, the supervisor bit, the saved supervisor bit and the current window pointer. The block also keeps a trap base register. The upper 20 bits of that register locate the trap table. Its low 12 bits record the type of the most recent trap, shifted left by four.

Each cycle the pipeline can present a hardware trap request, a software trap instruction, or a return-from-trap instruction. On trap entry the block forms the vector address. It saves the mode bits and rotates the window pointer down by one. It also hands back the current PC and next-PC so that the register file can write them into the new window's local registers 1 and 2.

On return the block restores the supervisor bit, turns traps back on and rotates the window up by one. It also gives the jump target. A software trap attempted while traps are off does not vector. It raises a one-cycle error-mode flag, and the halt policy is left to the surrounding core.

Top module: `trap_ctrl`

## Requirements
- R1: The trap vector is the trap base register with its low 12 bits cleared, OR'd with the 8-bit trap type placed at bits 11:4. The same value is written back into the trap base register. The next-PC output is the vector plus 4.
- R2: On trap entry the trap-enable bit is cleared, the saved-supervisor bit takes the old supervisor bit, and the supervisor bit is set.
- R3: On trap entry the window pointer becomes (cwp - 1) modulo NWIN, so window 0 wraps to NWIN-1.
- R4: On return from trap the supervisor bit takes the saved-supervisor bit and trap-enable is set. The window pointer becomes (cwp + 1) modulo NWIN, so window NWIN-1 wraps to 0. The saved-supervisor bit is unchanged, and the jump target is op_a + op_b.
- R5: The type of a software trap is 128 plus bits 6:0 of the 32-bit sum sw_op_a + sw_op_b.
- R6: A software trap while trap-enable is clear pulses err_mode for one cycle. It leaves all mode state and the base register unchanged, and it produces no trap_valid.
- R7: Hardware causes map to types as follows. Cause 1 gives 0x05 (window overflow). Cause 2 gives 0x06 (window underflow). Cause 3 gives 0x01 when hw_fetch is 1 and 0x09 when hw_fetch is 0 (access fault). Cause 0 and every cause value from 4 to 7 give 0x02 (illegal instruction). A hardware trap vectors whatever the state of trap-enable.
- R8: A request is accepted on a clock edge. trap_valid, annul_clr and rett_valid are high for exactly the following cycle, together with their address outputs, and the mode outputs already show the new state in that cycle.
- R9: When requests coincide, a hardware trap wins over a software trap, and both win over a return, which is then ignored. A base-register write changes only bits 31:12 and is ignored in a cycle with a trap entry.
- R10: Synchronous active-low reset sets supervisor=1, saved-supervisor=0, trap-enable=0, window pointer=0, base register=0, and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | 1 | Hardware trap request |
| hw_cause | input | 3 | Hardware trap cause code |
| hw_fetch | input | 1 | Failing access was an instruction fetch |
| sw_req | input | 1 | Software trap instruction |
| sw_op_a | input | 32 | Software trap operand A |
| sw_op_b | input | 32 | Software trap operand B |
| rett_req | input | 1 | Return-from-trap instruction |
| rett_op_a | input | 32 | Return target operand A |
| rett_op_b | input | 32 | Return target operand B |
| cur_pc | input | 32 | PC of the trapping instruction |
| cur_npc | input | 32 | Next-PC of the trapping instruction |
| base_wr | input | 1 | Write the trap base register |
| base_wdata | input | 32 | Data for the base register (bits 31:12 used) |
| trap_valid | output | 1 | One-cycle trap entry strobe |
| annul_clr | output | 1 | Clear pending delay-slot annul |
| trap_pc | output | 32 | New PC (trap vector) |
| trap_npc | output | 32 | New next-PC |
| save_l1 | output | 32 | Value for local register 1 |
| save_l2 | output | 32 | Value for local register 2 |
| rett_valid | output | 1 | One-cycle return strobe |
| rett_pc | output | 32 | Return jump target |
| err_mode | output | 1 | Error-mode flag strobe |
| mode_et | output | 1 | Trap-enable bit |
| mode_s | output | 1 | Supervisor bit |
| mode_ps | output | 1 | Saved-supervisor bit |
| cwp | output | $clog2(NWIN) | Current window pointer |
| trap_base | output | 32 | Trap base register |

## Verification
Trap entry is driven from user mode and from supervisor mode, so the saved-supervisor bit is seen taking both values. The window pointer is stepped down through window 0 and up through the top window, which separates correct wrapping from plain binary overflow when NWIN is not a power of two. Every hardware cause and both values of the fetch flag are applied, and software traps use operand sums that overflow 32 bits, so a wrong type encoding or a wrong shift shows up in the vector address. Requests are also made to coincide, and a software trap is issued with traps disabled, to show which request is ignored.

// File: rtl/trap_pkg.sv
// trap_pkg: shared widths, type codes and hardware cause codes for the
// trap controller. Assumes a 32-bit address space with a 20-bit table base.
package trap_pkg;
    localparam int ADDR_W  = 32;
    localparam int BASE_W  = 20;
    localparam int TT_W    = 8;
    localparam int TT_LSB  = 4;

    typedef logic [TT_W-1:0]   ttype_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // hardware cause codes on hw_cause
    localparam logic [2:0] CAUSE_ILLEGAL = 3'd0;
    localparam logic [2:0] CAUSE_WOVF    = 3'd1;
    localparam logic [2:0] CAUSE_WUNF    = 3'd2;
    localparam logic [2:0] CAUSE_ACCESS  = 3'd3;

    // trap type codes
    localparam ttype_t TT_IACCESS = 8'h01;
    localparam ttype_t TT_ILLEGAL = 8'h02;
    localparam ttype_t TT_WOVF    = 8'h05;
    localparam ttype_t TT_WUNF    = 8'h06;
    localparam ttype_t TT_DACCESS = 8'h09;
    localparam ttype_t TT_SW_BASE = 8'h80;
endpackage

// File: rtl/trap_cause_enc.sv
// trap_cause_enc: arbitrates the hardware and software trap sources and
// produces the trap type. Purely combinational. Assumes the caller
// qualifies the software path with trap-enable.
module trap_cause_enc
    import trap_pkg::*;
(
    input  logic        hw_req,
    input  logic [2:0]  hw_cause,
    input  logic        hw_fetch,
    input  logic        sw_req,
    input  addr_t       sw_op_a,
    input  addr_t       sw_op_b,
    output logic        any_req,
    output logic        sw_sel,
    output ttype_t      ttype
);
    addr_t  sw_sum;
    ttype_t hw_tt;
    ttype_t sw_tt;

    // software type: upper half of the type space, offset by the low 7 sum bits
    always_comb begin
        sw_sum = sw_op_a + sw_op_b;
        sw_tt  = TT_SW_BASE | {1'b0, sw_sum[6:0]};
    end

    // hardware type from the cause code; unknown causes count as illegal
    always_comb begin
        case (hw_cause)
            CAUSE_WOVF:   hw_tt = TT_WOVF;
            CAUSE_WUNF:   hw_tt = TT_WUNF;
            CAUSE_ACCESS: hw_tt = hw_fetch ? TT_IACCESS : TT_DACCESS;
            default:      hw_tt = TT_ILLEGAL;
        endcase
    end

    // hardware source wins over software
    always_comb begin
        any_req = hw_req | sw_req;
        sw_sel  = sw_req & ~hw_req;
        ttype   = sw_sel ? sw_tt : hw_tt;
    end

    always_comb begin
        if (sw_sel) begin
            a_sw_upper_r5: assert (ttype[7] == 1'b1);
        end
    end
endmodule

// File: rtl/trap_win_step.sv
// trap_win_step: window pointer neighbours modulo NWIN. For a power-of-two
// window count the natural binary wrap is used; otherwise the ends are
// compared explicitly. Assumes 2 <= NWIN <= 32 and cur < NWIN.
module trap_win_step #(
    parameter int NWIN  = 8,
    localparam int CWP_W = $clog2(NWIN)
) (
    input  logic [CWP_W-1:0] cur,
    output logic [CWP_W-1:0] down,
    output logic [CWP_W-1:0] up
);
    localparam logic [CWP_W-1:0] TOP = CWP_W'(NWIN - 1);

    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
            // binary wrap equals modulo wrap
            always_comb begin
                down = cur - 1'b1;
                up   = cur + 1'b1;
            end
        end else begin : g_mod
            // explicit wrap at both ends
            always_comb begin
                down = (cur == '0)  ? TOP : cur - 1'b1;
                up   = (cur == TOP) ? '0  : cur + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/trap_status.sv
// trap_status: mode bits, window pointer and trap base register. Applies
// trap entry, return, or base write; the caller guarantees that entry and
// return never arrive together.
module trap_status
    import trap_pkg::*;
#(
    parameter int NWIN  = 8,
    localparam int CWP_W = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_entry,
    input  logic             do_rett,
    input  ttype_t           entry_tt,
    input  logic             base_wr,
    input  addr_t            base_wdata,
    output logic             et,
    output logic             s,
    output logic             ps,
    output logic [CWP_W-1:0] cwp,
    output addr_t            tbr,
    output addr_t            vector
);
    logic [CWP_W-1:0] cwp_down;
    logic [CWP_W-1:0] cwp_up;

    trap_win_step #(.NWIN(NWIN)) u_step (
        .cur  (cwp),
        .down (cwp_down),
        .up   (cwp_up)
    );

    // vector: table base with the type in bits 11:4
    always_comb begin
        vector = {tbr[ADDR_W-1:ADDR_W-BASE_W], {(ADDR_W-BASE_W){1'b0}}}
               | (addr_t'(entry_tt) << TT_LSB);
    end

    // mode bits and window pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            et  <= 1'b0;
            s   <= 1'b1;
            ps  <= 1'b0;
            cwp <= '0;
        end else if (do_entry) begin
            et  <= 1'b0;
            ps  <= s;
            s   <= 1'b1;
            cwp <= cwp_down;
        end else if (do_rett) begin
            et  <= 1'b1;
            s   <= ps;
            cwp <= cwp_up;
        end
    end

    // base register: trap records its vector, software writes the base only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbr <= '0;
        end else if (do_entry) begin
            tbr <= vector;
        end else if (base_wr) begin
            tbr <= {base_wdata[ADDR_W-1:ADDR_W-BASE_W], tbr[ADDR_W-BASE_W-1:0]};
        end
    end

    p_cwp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cwp <= CWP_W'(NWIN - 1));

    p_entry_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_entry |=> (cwp == (($past(cwp) == '0) ? CWP_W'(NWIN - 1) : $past(cwp) - 1'b1)));

    p_rett_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_rett |=> (cwp == (($past(cwp) == CWP_W'(NWIN - 1)) ? '0 : $past(cwp) + 1'b1)));

    p_base_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tbr[3:0] == 4'h0);
endmodule

// File: rtl/trap_ctrl.sv
// trap_ctrl: top of the trap entry/return controller. Accepts one request
// per cycle (hardware > software > return), updates the mode state and
// presents the redirect and save values as one-cycle registered strobes.
// Assumes 2 <= NWIN <= 32.
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int NWIN  = 8,
    localparam int CWP_W = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_req,
    input  logic [2:0]       hw_cause,
    input  logic             hw_fetch,
    input  logic             sw_req,
    input  logic [31:0]      sw_op_a,
    input  logic [31:0]      sw_op_b,
    input  logic             rett_req,
    input  logic [31:0]      rett_op_a,
    input  logic [31:0]      rett_op_b,
    input  logic [31:0]      cur_pc,
    input  logic [31:0]      cur_npc,
    input  logic             base_wr,
    input  logic [31:0]      base_wdata,
    output logic             trap_valid,
    output logic             annul_clr,
    output logic [31:0]      trap_pc,
    output logic [31:0]      trap_npc,
    output logic [31:0]      save_l1,
    output logic [31:0]      save_l2,
    output logic             rett_valid,
    output logic [31:0]      rett_pc,
    output logic             err_mode,
    output logic             mode_et,
    output logic             mode_s,
    output logic             mode_ps,
    output logic [CWP_W-1:0] cwp,
    output logic [31:0]      trap_base
);
    logic   any_req;
    logic   sw_sel;
    ttype_t ttype;
    logic   do_entry;
    logic   do_rett;
    logic   do_err;
    addr_t  vector;

    trap_cause_enc u_enc (
        .hw_req   (hw_req),
        .hw_cause (hw_cause),
        .hw_fetch (hw_fetch),
        .sw_req   (sw_req),
        .sw_op_a  (sw_op_a),
        .sw_op_b  (sw_op_b),
        .any_req  (any_req),
        .sw_sel   (sw_sel),
        .ttype    (ttype)
    );

    // request qualification: a software trap needs traps enabled
    always_comb begin
        do_err   = sw_sel & ~mode_et;
        do_entry = any_req & ~do_err;
        do_rett  = rett_req & ~any_req;
    end

    trap_status #(.NWIN(NWIN)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_entry   (do_entry),
        .do_rett    (do_rett),
        .entry_tt   (ttype),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .et         (mode_et),
        .s          (mode_s),
        .ps         (mode_ps),
        .cwp        (cwp),
        .tbr        (trap_base),
        .vector     (vector)
    );

    // one-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            annul_clr  <= 1'b0;
            rett_valid <= 1'b0;
            err_mode   <= 1'b0;
        end else begin
            trap_valid <= do_entry;
            annul_clr  <= do_entry;
            rett_valid <= do_rett;
            err_mode   <= do_err;
        end
    end

    // redirect and save values, loaded only with their strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pc  <= '0;
            trap_npc <= '0;
            save_l1  <= '0;
            save_l2  <= '0;
            rett_pc  <= '0;
        end else begin
            if (do_entry) begin
                trap_pc  <= vector;
                trap_npc <= vector + 32'd4;
                save_l1  <= cur_pc;
                save_l2  <= cur_npc;
            end
            if (do_rett) begin
                rett_pc <= rett_op_a + rett_op_b;
            end
        end
    end

    p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_valid, rett_valid, err_mode}));

    p_vec_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_pc == trap_base) && (trap_pc[3:0] == 4'h0));

    p_entry_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        do_entry |=> (!mode_et && mode_s && (mode_ps == $past(mode_s))));

    p_rett_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_rett |=> (mode_et && (mode_s == $past(mode_ps)) && $stable(mode_ps)));

    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> ($stable(cwp) && $stable(mode_s) && $stable(mode_ps)
                      && !mode_et && $stable(trap_base)));

    p_annul_r8: assert property (@(posedge clk) disable iff (!rst_n)
        annul_clr == trap_valid);
endmodule

// File: tb/trap_ctrl_bench.sv
// trap_ctrl_bench: directed scenarios against a small reference model of
// the mode state kept in the bench.
module trap_ctrl_bench;
    localparam int NWIN = 8;
    localparam int CW   = $clog2(NWIN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_req = 0, hw_fetch = 0, sw_req = 0, rett_req = 0, base_wr = 0;
    logic [2:0]  hw_cause = 0;
    logic [31:0] sw_op_a = 0, sw_op_b = 0, rett_op_a = 0, rett_op_b = 0;
    logic [31:0] cur_pc = 0, cur_npc = 0, base_wdata = 0;
    logic trap_valid, annul_clr, rett_valid, err_mode, mode_et, mode_s, mode_ps;
    logic [31:0] trap_pc, trap_npc, save_l1, save_l2, rett_pc, trap_base;
    logic [CW-1:0] cwp;

    int n_run = 0;
    int n_fail = 0;

    // reference model
    logic m_et, m_s, m_ps;
    int   m_cwp;
    logic [31:0] m_tbr;

    always #2 clk = ~clk;

    trap_ctrl #(.NWIN(NWIN)) u_trap_ctrl (
        .clk(clk), .rst_n(rst_n),
        .hw_req(hw_req), .hw_cause(hw_cause), .hw_fetch(hw_fetch),
        .sw_req(sw_req), .sw_op_a(sw_op_a), .sw_op_b(sw_op_b),
        .rett_req(rett_req), .rett_op_a(rett_op_a), .rett_op_b(rett_op_b),
        .cur_pc(cur_pc), .cur_npc(cur_npc),
        .base_wr(base_wr), .base_wdata(base_wdata),
        .trap_valid(trap_valid), .annul_clr(annul_clr),
        .trap_pc(trap_pc), .trap_npc(trap_npc),
        .save_l1(save_l1), .save_l2(save_l2),
        .rett_valid(rett_valid), .rett_pc(rett_pc), .err_mode(err_mode),
        .mode_et(mode_et), .mode_s(mode_s), .mode_ps(mode_ps),
        .cwp(cwp), .trap_base(trap_base)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_mode(input string req);
        check({req, " et"}, 32'(mode_et), 32'(m_et));
        check({req, " s"}, 32'(mode_s), 32'(m_s));
        check({req, " ps"}, 32'(mode_ps), 32'(m_ps));
        check({req, " cwp"}, 32'(cwp), 32'(m_cwp));
        check({req, " base"}, trap_base, m_tbr);
    endtask

    // one request cycle: inputs set at negedge, released at the next negedge
    task automatic pulse();
        @(negedge clk);
        hw_req = 0; sw_req = 0; rett_req = 0; base_wr = 0;
    endtask

    // model of trap entry with the given type
    task automatic model_entry(input logic [7:0] tt, output logic [31:0] vec);
        vec   = {m_tbr[31:12], 12'h000} | (32'(tt) << 4);
        m_ps  = m_s;
        m_s   = 1'b1;
        m_et  = 1'b0;
        m_cwp = (m_cwp == 0) ? NWIN - 1 : m_cwp - 1;
        m_tbr = vec;
    endtask

    task automatic expect_trap(input string req, input logic [31:0] vec,
                               input logic [31:0] pc, input logic [31:0] npc);
        check({req, " trap_valid"}, 32'(trap_valid), 32'd1);
        check({req, " annul_clr"}, 32'(annul_clr), 32'd1);
        check({req, " trap_pc"}, trap_pc, vec);
        check({req, " trap_npc"}, trap_npc, vec + 32'd4);
        check({req, " save_l1"}, save_l1, pc);
        check({req, " save_l2"}, save_l2, npc);
        check_mode(req);
    endtask

    task automatic hw_trap(input string req, input logic [2:0] cause, input logic fetch,
                           input logic [7:0] exp_tt, input logic [31:0] pc);
        logic [31:0] vec;
        hw_req = 1; hw_cause = cause; hw_fetch = fetch;
        cur_pc = pc; cur_npc = pc + 4;
        model_entry(exp_tt, vec);
        pulse();
        expect_trap(req, vec, pc, pc + 4);
    endtask

    task automatic sw_trap(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic [7:0] exp_tt, input logic [31:0] pc);
        logic [31:0] vec;
        sw_req = 1; sw_op_a = a; sw_op_b = b;
        cur_pc = pc; cur_npc = pc + 4;
        model_entry(exp_tt, vec);
        pulse();
        expect_trap(req, vec, pc, pc + 4);
    endtask

    task automatic rett(input string req, input logic [31:0] a, input logic [31:0] b);
        rett_req = 1; rett_op_a = a; rett_op_b = b;
        m_et = 1'b1;
        m_s  = m_ps;
        m_cwp = (m_cwp == NWIN - 1) ? 0 : m_cwp + 1;
        pulse();
        check({req, " rett_valid"}, 32'(rett_valid), 32'd1);
        check({req, " trap_valid"}, 32'(trap_valid), 32'd0);
        check({req, " rett_pc"}, rett_pc, a + b);
        check_mode(req);
    endtask

    task automatic t_reset();
        check("R10 trap_valid", 32'(trap_valid), 32'd0);
        check("R10 rett_valid", 32'(rett_valid), 32'd0);
        check("R10 err_mode", 32'(err_mode), 32'd0);
        check_mode("R10");
    endtask

    task automatic t_sw_disabled();
        sw_req = 1; sw_op_a = 32'h10; sw_op_b = 32'h1;
        pulse();
        check("R6 err_mode", 32'(err_mode), 32'd1);
        check("R6 trap_valid", 32'(trap_valid), 32'd0);
        check_mode("R6");
        @(negedge clk);
        check("R6 err one cycle", 32'(err_mode), 32'd0);
    endtask

    task automatic t_base_write();
        base_wr = 1; base_wdata = 32'h4000_0ABC;
        m_tbr = {32'h4000_0, m_tbr[11:0]};
        pulse();
        check("R9 base write upper", trap_base, m_tbr);
    endtask

    task automatic t_priority();
        logic [31:0] vec;
        // hw and sw together: hw cause 2 wins
        hw_req = 1; hw_cause = 3'd2; sw_req = 1; sw_op_a = 32'h5; sw_op_b = 32'h0;
        rett_req = 1; rett_op_a = 32'h999; rett_op_b = 0;
        cur_pc = 32'h3000; cur_npc = 32'h3004;
        model_entry(8'h06, vec);
        pulse();
        check("R9 rett ignored", 32'(rett_valid), 32'd0);
        expect_trap("R9 hw over sw", vec, 32'h3000, 32'h3004);
        // trap with base write in same cycle: base write ignored
        hw_req = 1; hw_cause = 3'd1; base_wr = 1; base_wdata = 32'hFFFF_F000;
        cur_pc = 32'h3100; cur_npc = 32'h3104;
        model_entry(8'h05, vec);
        pulse();
        expect_trap("R9 base write during trap", vec, 32'h3100, 32'h3104);
    endtask

    task automatic t_strobe_width();
        @(negedge clk);
        check("R8 trap_valid drops", 32'(trap_valid), 32'd0);
        check("R8 annul_clr drops", 32'(annul_clr), 32'd0);
    endtask

    initial begin
        m_et = 0; m_s = 1; m_ps = 0; m_cwp = 0; m_tbr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sw_disabled();
        rett("R4 first return", 32'h100, 32'h20);     // s<=0, cwp 1
        t_base_write();
        hw_trap("R2 R7 overflow from user", 3'd1, 1'b0, 8'h05, 32'h1000);
        t_strobe_width();
        rett("R4 return to user", 32'h1000, 32'h4);
        sw_trap("R5 sw 0x82", 32'h7F, 32'h03, 8'h82, 32'h2000);   // cwp 0
        hw_trap("R3 wrap down", 3'd0, 1'b0, 8'h02, 32'h2100);      // cwp 7, ps=1
        rett("R4 wrap up", 32'h2100, 32'h0);                       // cwp 0
        hw_trap("R7 fetch fault", 3'd3, 1'b1, 8'h01, 32'h2200);
        hw_trap("R7 data fault", 3'd3, 1'b0, 8'h09, 32'h2300);
        hw_trap("R7 underflow", 3'd2, 1'b1, 8'h06, 32'h2400);
        hw_trap("R7 unknown cause", 3'd5, 1'b0, 8'h02, 32'h2500);
        rett("R4 enable again", 32'h0, 32'h2504);
        sw_trap("R5 sum overflow", 32'hFFFF_FFFF, 32'h0000_0081, 8'h80, 32'h2600);
        rett("R4 enable for sw", 32'h10, 32'h10);
        sw_trap("R1 sw max type", 32'h0000_007F, 32'h0, 8'hFF, 32'h2700);
        t_priority();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule